// File: doc/BRIEF.md
# Carry-save tree multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Every row of the multiplication is produced at once: row i is the multiplicand masked by bit i of the multiplier and moved up i places. The rows are then merged by a balanced tree of three-input, two-output carry-save cells. Each cell keeps its carries as a separate vector instead of rippling them. Only the last two vectors go through a real carry-propagate adder.

The tree depth grows with the logarithm of N to base 3/2. The final adder is either a ripple chain or a parallel-prefix network, chosen by a parameter. An optional output register, cleared by a synchronous active-low reset, lets the block sit in a clocked datapath with a latency of one cycle. With the register removed, the product follows the operands combinationally.

Top module: `csa_tree_mul`

## Requirements
- R1: `product_o` equals the unsigned product of `a_i` and `b_i`, formed at full 2N-bit width with no truncation.
- R2: With `OUT_REG`=1 (the default), the product of the operands present before a rising clock edge appears on `product_o` after that edge and not earlier. With `OUT_REG`=0 it follows the operands with no clock.
- R3: While `rst_n` is low at a rising edge, the registered product is zero after that edge, whatever the operands are.
- R4: If either operand is zero, the product is zero.
- R5: A multiplier of 1 returns the multiplicand unchanged in the low N bits, with zeros above. A multiplicand of 1 returns the multiplier in the same way.
- R6: All-ones times all-ones gives 2^(2N) - 2^(N+1) + 1, which is 0xFE01 for N=8. This sets the top product bit and needs a carry through the full adder width.
- R7: A multiplier with only bit i set returns the multiplicand moved up by exactly i places. This is row i of the partial products.
- R8: Operand patterns that put several ones in every column give the exact product. One such pattern is 0x55 times 0x55 = 0x1C39. This holds only if every carry vector moves one place up before the next stage uses it.
- R9: While both operands are held constant, `product_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| product_o | output | 2N | Unsigned product |

## Verification
The bench targets operands that stress carries. All-ones squared only comes out right if carries reach the top bit: a final adder that drops its last carry, or a tree that truncates a vector, returns a value wrong in the upper byte. The alternating-bit square and random operands fill every column. A cell that failed to move its carry vector up would give a product off by whole powers of two. Single-bit multipliers and unit operands expose partial products that are shifted wrongly or mapped to the wrong row. Zero operands, reset and the edge at which a new product appears catch a register that leaks stale data or adds a cycle.

// File: rtl/csa_mul_pkg.sv
// Package: compile-time helpers for sizing the carry-save reduction tree.
// Assumes operand counts of at least 2.
package csa_mul_pkg;

    // Number of vectors left after one layer of 3:2 cells acts on m vectors.
    function automatic int csa_next(input int m);
        return 2 * (m / 3) + (m % 3);
    endfunction

    // Number of 3:2 layers needed to bring m vectors down to two.
    function automatic int csa_depth(input int m);
        int c;
        int d;
        c = m;
        d = 0;
        while (c > 2) begin
            c = csa_next(c);
            d = d + 1;
        end
        return d;
    endfunction

    // Number of live vectors entering layer l when the tree starts with m.
    function automatic int csa_count(input int m, input int l);
        int c;
        c = m;
        for (int i = 0; i < l; i++) c = csa_next(c);
        return c;
    endfunction

endpackage

// File: rtl/csa_ppgen.sv
// Partial product generator: row i is the zero-extended multiplicand masked
// by multiplier bit i and moved up i places. Rows are packed side by side,
// each W bits wide, row 0 in the least significant slot.
// Assumes W >= 2*N so no row loses bits.
module csa_ppgen #(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [N*W-1:0] rows_o
);
    localparam int PAD = W - N;

    logic [W-1:0] a_ext;

    // Widen the multiplicand once for all rows.
    assign a_ext = {{PAD{1'b0}}, a_i};

    for (genvar i = 0; i < N; i++) begin : g_row
        // Mask by the multiplier bit, then align to weight 2^i.
        assign rows_o[i*W +: W] = (a_ext & {W{b_i[i]}}) << i;
    end
endmodule

// File: rtl/csa_cell.sv
// One 3:2 carry-save cell, W bits wide. The sum is the bitwise parity of the
// three inputs. The carry is the bitwise majority, moved up one place so it
// carries its true weight. The majority of the top bit falls outside W and is
// not formed. Assumes callers keep every value below 2^W.
module csa_cell #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-2:0] maj;

    // Bitwise parity gives the saved sum.
    assign sum_o   = x_i ^ y_i ^ z_i;
    // Majority over the lower W-1 bits only; the top one would be shifted out.
    assign maj     = (x_i[W-2:0] & y_i[W-2:0]) |
                     (x_i[W-2:0] & z_i[W-2:0]) |
                     (y_i[W-2:0] & z_i[W-2:0]);
    // Carries gain one place of weight.
    assign carry_o = {maj, 1'b0};
endmodule

// File: rtl/csa_reduce.sv
// Balanced carry-save reduction tree. It takes N packed rows of W bits and
// returns two W-bit vectors whose sum equals the sum of all rows modulo 2^W.
// Each layer groups live vectors in threes through csa_cell. One or two
// leftovers pass straight to the next layer. Slots past the live count are
// held at zero. Assumes N >= 2.
module csa_reduce #(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [N*W-1:0] rows_i,
    output logic [W-1:0]   sum_o,
    output logic [W-1:0]   carry_o
);
    import csa_mul_pkg::*;

    localparam int LV = csa_depth(N);

    logic [W-1:0] vec [0:LV][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        // Layer 0 holds the raw partial products.
        assign vec[0][i] = rows_i[i*W +: W];
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int M  = csa_count(N, l);
        localparam int G  = M / 3;
        localparam int R  = M % 3;
        localparam int O2 = 2 * G;

        for (genvar k = 0; k < N; k++) begin : g_grp
            if (k < G) begin : g_cell
                logic [W-1:0] s_w;
                logic [W-1:0] c_w;
                csa_cell #(.W(W)) u_cell (
                    .x_i     (vec[l][3*k]),
                    .y_i     (vec[l][3*k+1]),
                    .z_i     (vec[l][3*k+2]),
                    .sum_o   (s_w),
                    .carry_o (c_w)
                );
                // Group k writes its sum and its carry to the next layer.
                assign vec[l+1][2*k]   = s_w;
                assign vec[l+1][2*k+1] = c_w;
            end
        end

        for (genvar o = O2; o < N; o++) begin : g_rest
            if (o < O2 + R) begin : g_pass
                // A leftover vector moves on without change.
                assign vec[l+1][o] = vec[l][3*G + (o - O2)];
            end else begin : g_zero
                // This slot carries no vector.
                assign vec[l+1][o] = '0;
            end
        end
    end

    assign sum_o   = vec[LV][0];
    assign carry_o = vec[LV][1];
endmodule

// File: rtl/csa_cpa.sv
// Final carry-propagate adder on W bits, with the carry out dropped.
// PREFIX=1 builds a log-depth parallel-prefix carry network. PREFIX=0
// builds a ripple chain with fewer cells and a longer path.
module csa_cpa #(
    parameter int W      = 16,
    parameter bit PREFIX = 1'b1
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] half;

    // Per-bit propagate term, shared by both variants.
    assign half = x_i ^ y_i;

    if (PREFIX) begin : g_prefix
        logic [W-1:0] gen;
        logic [W-1:0] prp;
        logic [W-1:0] gen_n;
        logic [W-1:0] prp_n;

        // Combine generate and propagate spans of doubling distance.
        always_comb begin
            gen   = x_i & y_i;
            prp   = half;
            gen_n = gen;
            prp_n = prp;
            for (int d = 1; d < W; d = d * 2) begin
                gen_n = gen;
                prp_n = prp;
                for (int i = 0; i < W; i++) begin
                    if (i >= d) begin
                        gen_n[i] = gen[i] | (prp[i] & gen[i-d]);
                        prp_n[i] = prp[i] & prp[i-d];
                    end
                end
                gen = gen_n;
                prp = prp_n;
            end
        end

        // The carry into bit i is the group generate of bits below it.
        assign sum_o = half ^ {gen[W-2:0], 1'b0};
    end else begin : g_ripple
        logic cy;

        // Pass one carry up through the bits in turn.
        always_comb begin
            cy    = 1'b0;
            sum_o = '0;
            for (int i = 0; i < W; i++) begin
                sum_o[i] = half[i] ^ cy;
                cy       = (x_i[i] & y_i[i]) | (cy & half[i]);
            end
        end
    end
endmodule

// File: rtl/csa_tree_mul.sv
// Unsigned N x N multiplier. Partial products come from masking, a 3:2
// carry-save tree merges them, and one carry-propagate adder forms the 2N-bit
// result. OUT_REG=1 adds a result register with synchronous active-low reset.
// Assumes N >= 2 and unsigned operands.
module csa_tree_mul #(
    parameter int N          = 8,
    parameter bit OUT_REG    = 1'b1,
    parameter bit PREFIX_CPA = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] product_o
);
    localparam int W = 2 * N;

    logic [N*W-1:0] rows;
    logic [W-1:0]   tree_sum;
    logic [W-1:0]   tree_carry;
    logic [W-1:0]   prod_comb;

    csa_ppgen #(.N(N), .W(W)) u_pp (
        .a_i    (a_i),
        .b_i    (b_i),
        .rows_o (rows)
    );

    csa_reduce #(.N(N), .W(W)) u_tree (
        .rows_i  (rows),
        .sum_o   (tree_sum),
        .carry_o (tree_carry)
    );

    csa_cpa #(.W(W), .PREFIX(PREFIX_CPA)) u_cpa (
        .x_i   (tree_sum),
        .y_i   (tree_carry),
        .sum_o (prod_comb)
    );

    if (OUT_REG) begin : g_reg
        logic [W-1:0] prod_q;

        // Capture the product each cycle; clear it while reset is held.
        always_ff @(posedge clk) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= prod_comb;
        end

        assign product_o = prod_q;
    end else begin : g_comb
        assign product_o = prod_comb;
    end
endmodule

// File: rtl/csa_mul_chk.sv
// Property checker for csa_tree_mul, attached by bind. It checks the product
// at the ports against the operands, and checks that the tree's two output
// vectors add up to the product. The time relation depends on OUT_REG.
module csa_mul_chk #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a_i,
    input logic [N-1:0]   b_i,
    input logic [2*N-1:0] product_o,
    input logic [2*N-1:0] tree_sum,
    input logic [2*N-1:0] tree_carry
);
    localparam int W = 2 * N;

    // R8: the saved sum and carry vectors must add to the true product.
    assert_tree_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (W'(tree_sum + tree_carry) == W'(W'(a_i) * W'(b_i))));

    if (OUT_REG) begin : g_seq
        // R1 and R2: the product appears one edge after the operands.
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (product_o == W'(W'($past(a_i)) * W'($past(b_i)))));

        // R4: a zero operand gives zero at the next edge.
        assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((a_i == '0) || (b_i == '0)) |=> (product_o == '0));

        // R5: a unit multiplier passes the multiplicand through.
        assert_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (b_i == N'(1)) |=> (product_o == W'($past(a_i))));

        // R9: held operands keep the product steady.
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(a_i) && $stable(b_i)) |=> $stable(product_o));
    end else begin : g_cmb
        // R1: the combinational product matches the operands.
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (product_o == W'(W'(a_i) * W'(b_i))));

        // R4: a zero operand gives zero.
        assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((a_i == '0) || (b_i == '0)) |-> (product_o == '0));

        // R5: a unit multiplier passes the multiplicand through.
        assert_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (b_i == N'(1)) |-> (product_o == W'(a_i)));

        // R9: held operands keep the product steady.
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(a_i) && $stable(b_i)) |-> $stable(product_o));
    end
endmodule

bind csa_tree_mul csa_mul_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_i        (a_i),
    .b_i        (b_i),
    .product_o  (product_o),
    .tree_sum   (tree_sum),
    .tree_carry (tree_carry)
);

// File: tb/sim_csa_tree_mul.sv
// Directed bench for csa_tree_mul with default parameters (N=8, registered
// output). Inputs change on falling edges, and results are read on the
// following falling edge, one rising edge later.
module sim_csa_tree_mul;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [W-1:0] product;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    csa_tree_mul u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_i       (a),
        .b_i       (b),
        .product_o (product)
    );

    // 125 MHz clock: 8 ns period.
    always #4 clk = ~clk;

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        return W'(x) * W'(y);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one pair and read the product after one rising edge.
    task automatic apply(input string req, input logic [N-1:0] x, input logic [N-1:0] y,
                         input logic [W-1:0] exp);
        @(negedge clk);
        a = x;
        b = y;
        @(negedge clk);
        check(req, product, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a = 8'hAB;
        b = 8'hCD;
        repeat (3) @(negedge clk);
        check("R3 reset clears", product, '0);
        rst_n = 1'b1;
        #2;
        check("R2 no output before edge", product, '0);
        @(negedge clk);
        check("R2 one-edge latency", product, ref_mul(8'hAB, 8'hCD));
    endtask

    task automatic t_latency();
        @(negedge clk);
        a = 8'h12;
        b = 8'h34;
        #2;
        check("R2 old value held until edge", product, ref_mul(8'hAB, 8'hCD));
        @(negedge clk);
        check("R2 new value after edge", product, ref_mul(8'h12, 8'h34));
    endtask

    task automatic t_zero();
        apply("R4 a zero", 8'h00, 8'hFF, '0);
        apply("R4 b zero", 8'hC3, 8'h00, '0);
        apply("R4 both zero", 8'h00, 8'h00, '0);
    endtask

    task automatic t_unit();
        apply("R5 b one", 8'hA7, 8'h01, 16'h00A7);
        apply("R5 a one", 8'h01, 8'h5E, 16'h005E);
        apply("R5 one by one", 8'h01, 8'h01, 16'h0001);
    endtask

    task automatic t_ones();
        apply("R6 all ones squared", 8'hFF, 8'hFF, 16'hFE01);
        apply("R6 all ones by two", 8'hFF, 8'h02, 16'h01FE);
    endtask

    task automatic t_rows();
        for (int i = 0; i < N; i++) begin
            apply("R7 single-bit multiplier", 8'hB5, N'(1) << i, W'(16'h00B5 << i));
        end
    endtask

    task automatic t_dense();
        apply("R8 alternating squared", 8'h55, 8'h55, 16'h1C39);
        apply("R8 complementary alternating", 8'hAA, 8'h55, 16'h3872);
        apply("R8 high-bit heavy", 8'hF0, 8'hEF, ref_mul(8'hF0, 8'hEF));
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] x;
            logic [N-1:0] y;
            x = N'($urandom);
            y = N'($urandom);
            apply("R1 random product", x, y, ref_mul(x, y));
        end
    endtask

    task automatic t_hold();
        apply("R9 load pair", 8'h9C, 8'h6B, ref_mul(8'h9C, 8'h6B));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 product steady", product, ref_mul(8'h9C, 8'h6B));
        end
    endtask

    task automatic t_midreset();
        apply("R1 before reset", 8'h77, 8'h88, ref_mul(8'h77, 8'h88));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 reset during operation", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 resumes after reset", product, ref_mul(8'h77, 8'h88));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Scenario sequence.
    initial begin
        void'($urandom(32'h1F2E3D4C));
        t_reset();
        t_latency();
        t_zero();
        t_unit();
        t_ones();
        t_rows();
        t_dense();
        t_hold();
        t_midreset();
        t_random();
        finish_run();
    end
endmodule